// File: doc/BRIEF.md
# Downstream Port Power Manager

This block switches supply power to the downstream ports of a hub. It drives one active-low power-enable output per port and watches one active-low over-current input per port. It accepts single-cycle power-on and power-off requests from the hub controller. For every port it returns a powered bit, a filtered over-current bit and a sticky over-current change bit, which the hub status logic reads and acknowledges.

A static mode input selects individual or gang switching. In individual mode each port has its own enable output and its own over-current input. In gang mode all ports form one group. Only the first port's enable output is driven, only the first port's over-current input is watched, and the group stays powered while any active port still requests power. A count input sets how many ports are in use, from 2 up to the build maximum. Ports above that count stay dark. The global suspend input forces every enable output off and leaves the status bits unchanged.

Top module: `dsport_power_mgr`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `pwr_en_n` bit is 1 and `port_pwr`, `port_oc` and `port_oc_chg` are all zero.
- R2: In individual mode, a `pwr_on_req[p]` pulse powers port p and a `pwr_off_req[p]` pulse unpowers it. The result appears on `port_pwr[p]` after the sampling edge, and at the same edge `pwr_en_n[p]` goes low exactly when the port is powered. When both requests arrive in the same cycle, the off request wins.
- R3: Over-current inputs are double-synchronized and then debounced. A low level on `oc_n[p]` held for `FILT_CYC` cycles shows up on `port_oc[p]` at the (`FILT_CYC`+2)-th rising edge after it is applied. A low pulse of `FILT_CYC`-1 cycles or shorter is not reported and has no effect on power.
- R4: The edge at which the filtered over-current of a monitored input rises unpowers the affected port, and its enable output goes high at that same edge. Other ports are not affected. This cut wins over a power-on request for the same port in the same cycle.
- R5: While the monitored over-current of a port is asserted, a power-on request for that port is ignored.
- R6: `port_oc_chg[p]` is set when the filtered over-current of the monitored input rises. It holds until an `oc_chg_clr[p]` pulse clears it. If the set and the clear fall in the same cycle, the bit ends up set.
- R7: In gang mode, a power-on request on any active port powers the whole group, and `port_pwr` shows 1 on every active port. The group is unpowered only after every port that requested power has been sent a power-off request. Only `pwr_en_n[0]` is driven; all other enable bits stay 1.
- R8: In gang mode, only `oc_n[0]` is monitored. When it trips, the whole group is unpowered, and `port_oc` and `port_oc_chg` are set on every active port. Over-current on any other input has no effect.
- R9: Port p is active when p < `port_cnt`. A count below 2 acts as 2, and a count above `NPORTS` acts as `NPORTS`. Inactive ports keep `pwr_en_n` at 1 and report 0 on `port_pwr`, `port_oc` and `port_oc_chg`. Requests and over-current on inactive ports are ignored.
- R10: While `suspend` is 1, every `pwr_en_n` bit is 1 from the next edge on, and `port_pwr` keeps its value. When `suspend` drops, the enable outputs return to the powered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gang_mode | input | 1 | 1: gang switching, 0: individual switching |
| port_cnt | input | $clog2(NPORTS+1) | Number of ports in use |
| suspend | input | 1 | Global suspend, forces all enables off |
| pwr_on_req | input | NPORTS | Per-port power-on request pulse |
| pwr_off_req | input | NPORTS | Per-port power-off request pulse |
| oc_chg_clr | input | NPORTS | Per-port change-bit clear pulse |
| oc_n | input | NPORTS | Active-low over-current inputs |
| pwr_en_n | output | NPORTS | Active-low power-enable outputs |
| port_pwr | output | NPORTS | Port powered status |
| port_oc | output | NPORTS | Filtered over-current status |
| port_oc_chg | output | NPORTS | Sticky over-current change status |

## Verification
The interesting collision is an over-current trip that lands in the same cycle as both a power-on request and a change-bit clear for the same port. The bench counts edges from the moment it pulls `oc_n` low. It confirms that the port is still powered and still reports no over-current one edge before the trip. It then issues both pulses on exactly the trip edge and expects the port to be unpowered with its change bit set. Random request traffic, including on and off requests that collide, is compared each cycle against a bench model in both switching modes.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int DPM_MAX_PORTS = 4;
    localparam int DPM_MIN_PORTS = 2;
    localparam int DPM_FILT_DEF  = 4;
endpackage

// File: rtl/dpm_oc_filter.sv
module dpm_oc_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n,
    output logic oc_flt,
    output logic oc_rise
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          flt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        oc_rise = 1'b0;
        st_d.s1 = ~oc_n;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.flt) begin
            if (st_q.cnt == CW'(FILT_CYC - 1)) begin
                st_d.flt = st_q.s2;
                st_d.cnt = '0;
                oc_rise  = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_flt = st_q.flt;

    // R3: the filtered level only moves after a full run of mismatching cycles
    assert_flt_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flt != $past(st_q.flt)) |-> ($past(st_q.cnt) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/dpm_port_ctrl.sv
module dpm_port_ctrl #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gang_mode,
    input  logic              suspend,
    input  logic [NPORTS-1:0] active,
    input  logic [NPORTS-1:0] on_req,
    input  logic [NPORTS-1:0] off_req,
    input  logic [NPORTS-1:0] chg_clr,
    input  logic [NPORTS-1:0] oc_flt,
    input  logic [NPORTS-1:0] oc_rise,
    output logic [NPORTS-1:0] pwr_en_n,
    output logic [NPORTS-1:0] port_pwr,
    output logic [NPORTS-1:0] port_oc,
    output logic [NPORTS-1:0] port_oc_chg
);
    typedef struct packed {
        logic [NPORTS-1:0] want;
        logic [NPORTS-1:0] chg;
        logic [NPORTS-1:0] en_n;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [NPORTS-1:0] trip_v, block_on;

    always_comb begin
        st_d = st_q;
        if (gang_mode) begin
            trip_v   = {NPORTS{oc_rise[0]}};
            block_on = {NPORTS{oc_flt[0] | oc_rise[0]}};
        end else begin
            trip_v   = oc_rise;
            block_on = oc_flt | oc_rise;
        end
        st_d.want = (st_q.want | (on_req & ~block_on)) & ~off_req & ~trip_v & active;
        st_d.chg  = ((st_q.chg & ~chg_clr) | trip_v) & active;
        st_d.en_n = '1;
        if (!suspend) begin
            if (gang_mode) st_d.en_n[0] = ~(|st_d.want);
            else           st_d.en_n    = ~st_d.want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.en_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_en_n    = st_q.en_n;
    assign port_pwr    = gang_mode ? ({NPORTS{|st_q.want}} & active) : (st_q.want & active);
    assign port_oc     = gang_mode ? ({NPORTS{oc_flt[0]}} & active) : (oc_flt & active);
    assign port_oc_chg = st_q.chg & active;

    assert_susp_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> (&pwr_en_n));

    if (NPORTS > 1) begin : g_gang_chk
        assert_gang_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gang_mode |=> (&pwr_en_n[NPORTS-1:1]));
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        assert_trip_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!gang_mode && oc_rise[p]) |=> (pwr_en_n[p] && !st_q.want[p]));
        assert_chg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.chg[p] && !chg_clr[p] && active[p]) |=> st_q.chg[p]);
        assert_inactive_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !active[p] |=> pwr_en_n[p]);
    end
endmodule

// File: rtl/dsport_power_mgr.sv
module dsport_power_mgr #(
    parameter int NPORTS   = dpm_pkg::DPM_MAX_PORTS,
    parameter int FILT_CYC = dpm_pkg::DPM_FILT_DEF,
    localparam int CNT_W   = $clog2(NPORTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gang_mode,
    input  logic [CNT_W-1:0]  port_cnt,
    input  logic              suspend,
    input  logic [NPORTS-1:0] pwr_on_req,
    input  logic [NPORTS-1:0] pwr_off_req,
    input  logic [NPORTS-1:0] oc_chg_clr,
    input  logic [NPORTS-1:0] oc_n,
    output logic [NPORTS-1:0] pwr_en_n,
    output logic [NPORTS-1:0] port_pwr,
    output logic [NPORTS-1:0] port_oc,
    output logic [NPORTS-1:0] port_oc_chg
);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(dpm_pkg::DPM_MIN_PORTS);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NPORTS);

    logic [CNT_W-1:0]  cnt_eff;
    logic [NPORTS-1:0] active, oc_flt, oc_rise;

    always_comb begin
        if (port_cnt < CNT_MIN)      cnt_eff = CNT_MIN;
        else if (port_cnt > CNT_MAX) cnt_eff = CNT_MAX;
        else                         cnt_eff = port_cnt;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign active[p] = (CNT_W'(p) < cnt_eff);
        dpm_oc_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc_n    (oc_n[p]),
            .oc_flt  (oc_flt[p]),
            .oc_rise (oc_rise[p])
        );
    end

    dpm_port_ctrl #(.NPORTS(NPORTS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gang_mode   (gang_mode),
        .suspend     (suspend),
        .active      (active),
        .on_req      (pwr_on_req),
        .off_req     (pwr_off_req),
        .chg_clr     (oc_chg_clr),
        .oc_flt      (oc_flt),
        .oc_rise     (oc_rise),
        .pwr_en_n    (pwr_en_n),
        .port_pwr    (port_pwr),
        .port_oc     (port_oc),
        .port_oc_chg (port_oc_chg)
    );

    assert_min_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active[0] && active[1]));
endmodule

// File: tb/dsport_power_mgr_tb.sv
module dsport_power_mgr_tb;
    localparam int N = 4;
    localparam int F = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gang_mode = 1'b0;
    logic [2:0] port_cnt = 3'd4;
    logic suspend = 1'b0;
    logic [N-1:0] pwr_on_req = '0, pwr_off_req = '0, oc_chg_clr = '0, oc_n = '1;
    logic [N-1:0] pwr_en_n, port_pwr, port_oc, port_oc_chg;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dsport_power_mgr #(.NPORTS(N), .FILT_CYC(F)) u_dut (
        .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode), .port_cnt(port_cnt),
        .suspend(suspend), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .oc_chg_clr(oc_chg_clr), .oc_n(oc_n), .pwr_en_n(pwr_en_n),
        .port_pwr(port_pwr), .port_oc(port_oc), .port_oc_chg(port_oc_chg)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        pwr_on_req = '0; pwr_off_req = '0; oc_chg_clr = '0;
    endtask

    task automatic wait_n(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic do_reset(input logic g, input logic [2:0] c);
        @(negedge clk);
        rst_n = 1'b0; gang_mode = g; port_cnt = c; oc_n = '1; suspend = 1'b0;
        pwr_on_req = '0; pwr_off_req = '0; oc_chg_clr = '0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    function automatic logic [N-1:0] act_mask(input logic [2:0] c);
        int e = (c < 2) ? 2 : ((c > N) ? N : int'(c));
        logic [N-1:0] m = '0;
        for (int p = 0; p < N; p++) m[p] = (p < e);
        return m;
    endfunction

    function automatic logic [N-1:0] exp_pwr(input logic [N-1:0] w, input logic g, input logic [N-1:0] a);
        return g ? ({N{|w}} & a) : (w & a);
    endfunction

    function automatic logic [N-1:0] exp_en(input logic [N-1:0] w, input logic g, input logic s);
        if (s) return '1;
        return g ? {{(N-1){1'b1}}, ~(|w)} : ~w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] wm, am, on_r, off_r;
        void'($urandom(32'h5eed_0042));

        // R1 reset state
        @(negedge clk);
        chk("R1 en_n in reset", pwr_en_n, 4'b1111);
        do_reset(1'b0, 3'd4);
        chk("R1 en_n", pwr_en_n, 4'b1111);
        chk("R1 pwr", port_pwr, 4'b0000);
        chk("R1 oc", port_oc | port_oc_chg, 4'b0000);

        // R2 individual on/off
        pwr_on_req = 4'b0010; tick();
        chk("R2 pwr", port_pwr, 4'b0010);
        chk("R2 en_n", pwr_en_n, 4'b1101);
        pwr_on_req = 4'b0001; pwr_off_req = 4'b0001; tick();
        chk("R2 off wins", port_pwr, 4'b0010);

        // R3 short glitch ignored
        pwr_on_req = 4'b0100; tick();
        oc_n[2] = 1'b0; wait_n(F - 1); oc_n[2] = 1'b1; wait_n(8);
        chk("R3 glitch oc", port_oc, 4'b0000);
        chk("R3 glitch pwr", port_pwr, 4'b0110);

        // R4 / R6 sustained over-current on port 2
        oc_n[2] = 1'b0; wait_n(F + 4);
        chk("R3 oc seen", port_oc, 4'b0100);
        chk("R4 cut port2", port_pwr, 4'b0010);
        chk("R4 en_n", pwr_en_n, 4'b1101);
        chk("R6 chg set", port_oc_chg, 4'b0100);
        // R5 on request blocked during over-current
        pwr_on_req = 4'b0100; tick();
        chk("R5 blocked", port_pwr, 4'b0010);
        wait_n(3);
        chk("R6 chg held", port_oc_chg, 4'b0100);
        oc_chg_clr = 4'b0100; tick();
        chk("R6 chg cleared", port_oc_chg, 4'b0000);
        oc_n[2] = 1'b1; wait_n(F + 4);
        chk("R3 oc released", port_oc, 4'b0000);

        // R4/R6 collision: trip, power-on and clear on the same edge
        pwr_on_req = 4'b1000; tick();
        oc_n[3] = 1'b0;
        wait_n(F + 1);
        chk("R3 not yet", port_oc, 4'b0000);
        chk("R4 still on", port_pwr, 4'b1010);
        pwr_on_req = 4'b1000; oc_chg_clr = 4'b1000; tick();
        chk("R4 trip beats on", port_pwr, 4'b0010);
        chk("R4 en_n cut", pwr_en_n, 4'b1101);
        chk("R3 exact edge", port_oc, 4'b1000);
        chk("R6 set beats clr", port_oc_chg, 4'b1000);
        oc_n[3] = 1'b1; wait_n(F + 4);

        // R10 suspend
        suspend = 1'b1; tick();
        chk("R10 en_n dark", pwr_en_n, 4'b1111);
        chk("R10 pwr kept", port_pwr, 4'b0010);
        suspend = 1'b0; tick();
        chk("R10 en_n back", pwr_en_n, 4'b1101);

        // R9 port count
        do_reset(1'b0, 3'd2);
        pwr_on_req = 4'b1111; tick();
        chk("R9 cnt2 pwr", port_pwr, 4'b0011);
        chk("R9 cnt2 en_n", pwr_en_n, 4'b1100);
        oc_n[3] = 1'b0; wait_n(F + 4);
        chk("R9 inactive oc", port_oc | port_oc_chg, 4'b0000);
        oc_n[3] = 1'b1;
        do_reset(1'b0, 3'd7);
        pwr_on_req = 4'b1111; tick();
        chk("R9 clamp high", port_pwr, 4'b1111);
        do_reset(1'b0, 3'd0);
        pwr_on_req = 4'b1111; tick();
        chk("R9 clamp low", port_pwr, 4'b0011);

        // R7 / R8 gang mode
        do_reset(1'b1, 3'd3);
        pwr_on_req = 4'b0100; tick();
        chk("R7 group on", port_pwr, 4'b0111);
        chk("R7 single en", pwr_en_n, 4'b1110);
        pwr_on_req = 4'b0001; tick();
        pwr_off_req = 4'b0100; tick();
        chk("R7 still held", port_pwr, 4'b0111);
        pwr_off_req = 4'b0001; tick();
        chk("R7 group off", port_pwr, 4'b0000);
        chk("R7 en off", pwr_en_n, 4'b1111);
        pwr_on_req = 4'b1000; tick();
        chk("R9 gang inactive req", port_pwr, 4'b0000);
        pwr_on_req = 4'b0010; tick();
        oc_n[1] = 1'b0; wait_n(F + 4);
        chk("R8 other oc ignored", port_pwr, 4'b0111);
        chk("R8 other oc no report", port_oc, 4'b0000);
        oc_n[1] = 1'b1; oc_n[0] = 1'b0; wait_n(F + 4);
        chk("R8 group cut", port_pwr, 4'b0000);
        chk("R8 group en", pwr_en_n, 4'b1111);
        chk("R8 group oc", port_oc, 4'b0111);
        chk("R8 group chg", port_oc_chg, 4'b0111);
        oc_n[0] = 1'b1; wait_n(F + 4);

        // R2/R7/R9/R10 random request traffic against a model
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic g = cfg[0];
            logic [2:0] c = 3'($urandom_range(0, 7));
            do_reset(g, c);
            am = act_mask(c);
            wm = '0;
            for (int cy = 0; cy < 250; cy++) begin
                on_r  = 4'($urandom) & 4'($urandom);
                off_r = 4'($urandom) & 4'($urandom) & 4'($urandom);
                pwr_on_req = on_r; pwr_off_req = off_r;
                oc_chg_clr = 4'($urandom);
                suspend = ($urandom_range(0, 15) == 0);
                wm = (wm | on_r) & ~off_r & am;
                tick();
                chk(g ? "R7 rand pwr" : "R2 rand pwr", port_pwr, exp_pwr(wm, g, am));
                chk(suspend ? "R10 rand en" : "R9 rand en", pwr_en_n, exp_en(wm, g, suspend));
            end
            suspend = 1'b0;
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule